// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial bus slave that holds six 8-bit configuration registers for a clock generator and presents them as one parallel bus to the logic they control. A bus master writes them with a framed block transfer. The address byte comes first. A command byte and a count byte follow; both are acknowledged and then thrown away. After them come data bytes, which land in register 0, register 1 and so on in strict order. A stop may follow any complete byte. Registers that were already written keep their new values, and the others are left alone.

A read transfer opens with a byte that holds the register count (6). The six registers follow in order, each sent most significant bit first, and the master acknowledges each byte. Both bus lines are sampled by a system clock that runs much faster than the bus, which is limited to standard-rate traffic. The data line is driven in open-drain style: the block only ever pulls it low.

The serial bus has no way to stall the master, because clock stretching is not supported. The block therefore has no valid/ready handshake. A received data byte is written into its register in the same cycle the acknowledge is driven. The register bus is a plain level output that consumers may sample at any time.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, the register bus carries reg0=0x87, reg1=0xFF, reg2=0xFF, reg3=0x06, reg4=0x00, reg5=0x00, with reg0 in bits 7:0 and reg k in bits 8k+7:8k, and `sda_oe` is low.
- R2: The 7-bit device address is 0x69: address byte 0xD2 selects a write and 0xD3 selects a read, with the direction in bit 0. Any other address byte gets no acknowledge. The block then stays silent until the next start and changes no register.
- R3: In a write, every received byte (command, count and each data byte) is acknowledged: `sda_oe` is high during the ninth SCL pulse. `sda_oe` only ever rises while SCL is low.
- R4: The command and count bytes change no register, and a stop right after the address or after the count leaves every register unchanged.
- R5: Data byte n of a write goes into reg n, starting at reg0 in every transfer. A stop after any complete byte keeps the bytes already written and leaves the higher registers unchanged. Registers only change while SCL is low.
- R6: Data bytes beyond the sixth are still acknowledged but are dropped. Each write reaches the register bank as a single one-cycle strobe with an index below 6.
- R7: A read sends the count byte 0x06 first, then reg0 through reg5, most significant bit first.
- R8: A master NACK ends a read: the data line is released and stays released until the next start. Bytes read past reg5 return 0xFF.
- R9: A start seen at any point aborts the current transfer and begins a new one with an address byte. A write after such a restart begins again at reg0.
- R10: While the block is idle (after reset, a stop, a NACK or an address mismatch), `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset, restores default register values |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| regs_o | output | 48 | Register bus, reg k in bits 8k+7:8k |

## Verification
A bit counter or state machine that is out of step shows up at the pins within one bus byte. Either an acknowledge goes missing on the ninth clock, or read data comes back shifted by one bit position, or a register changes with the wrong value or at the wrong index. Every write therefore has its acknowledges checked and the register bus compared at once. Every write is also followed by a full read, so any corruption of the stored contents or of the transmit path appears within the next seven bytes. Address mismatch, early NACK, reads past the end and an aborted write are driven one at a time, so that a stuck drive of the data line shows as a wrong byte on the next read.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } xfer_state_t;

  localparam int HDR_BYTES = 2;  // command + count bytes ahead of write data
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_seen,
  output logic stop_seen
);
  localparam int PW = SYNC_STAGES + 1;

  logic [1:0] line_in;
  logic [PW-1:0] pipe [2];

  assign line_in = {sda_i, scl_i};

  // one synchronizer chain plus one history flop per bus line
  for (genvar g = 0; g < 2; g++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[g] <= '1;
      else        pipe[g] <= {pipe[g][PW-2:0], line_in[g]};
    end
  end

  logic scl_cur, scl_prev, sda_cur, sda_prev;
  assign scl_cur  = pipe[0][PW-2];
  assign scl_prev = pipe[0][PW-1];
  assign sda_cur  = pipe[1][PW-2];
  assign sda_prev = pipe[1][PW-1];

  assign sda_lvl    = sda_cur;
  assign scl_rise   = scl_cur & ~scl_prev;
  assign scl_fall   = ~scl_cur & scl_prev;
  assign start_seen = scl_cur & scl_prev & sda_prev & ~sda_cur;
  assign stop_seen  = scl_cur & scl_prev & ~sda_prev & sda_cur;
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int            NREG     = 6,
  parameter logic [NREG*8-1:0] DEFAULTS = '0,
  localparam int           IW       = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_idx,
  input  logic [7:0]        wr_data,
  output logic [NREG*8-1:0] regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_o[g*8 +: 8] <= DEFAULTS[g*8 +: 8];
      else if (wr_en && wr_idx == IW'(g))
        regs_o[g*8 +: 8] <= wr_data;
    end
  end
endmodule

// File: rtl/i2c_cfg_engine.sv
module i2c_cfg_engine
  import cfg_i2c_pkg::*;
#(
  parameter int         NREG     = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  localparam int        IW       = $clog2(NREG),
  localparam int        RW       = $clog2(NREG + 1),
  localparam int        CW       = $clog2(NREG + HDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_seen,
  input  logic              stop_seen,
  input  logic [NREG*8-1:0] rd_bus,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [IW-1:0]     wr_idx,
  output logic [7:0]        wr_data,
  output logic              idle
);
  localparam logic [7:0]    LEN_BYTE = 8'(NREG);
  localparam logic [CW-1:0] WB_MAX   = CW'(NREG + HDR_BYTES);
  localparam logic [CW-1:0] WB_HDR   = CW'(HDR_BYTES);

  xfer_state_t st;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg;
  logic          rw;
  logic          mack;
  logic [CW-1:0] wb_cnt;
  logic [RW-1:0] rd_cnt;
  logic [7:0]    rd_arr [NREG];
  logic [7:0]    tx_next;

  for (genvar g = 0; g < NREG; g++) begin : g_unpack
    assign rd_arr[g] = rd_bus[g*8 +: 8];
  end

  always_comb begin
    tx_next = 8'hFF;
    if (rd_cnt < RW'(NREG)) tx_next = rd_arr[IW'(rd_cnt)];
  end

  assign idle = (st == ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      bitcnt  <= '0;
      shreg   <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      wb_cnt  <= '0;
      rd_cnt  <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_idx  <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_seen) begin
        st     <= ST_ADDR;
        bitcnt <= '0;
        sda_oe <= 1'b0;
      end else if (stop_seen) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_RX: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_lvl};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  sda_oe <= 1'b1;
                  st     <= ST_ADDR_ACK;
                  rw     <= shreg[0];
                  wb_cnt <= '0;
                  rd_cnt <= '0;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_RX_ACK;
                if (wb_cnt >= WB_HDR && wb_cnt < WB_MAX) begin
                  wr_en   <= 1'b1;
                  wr_idx  <= IW'(wb_cnt - WB_HDR);
                  wr_data <= shreg;
                end
                if (wb_cnt != WB_MAX) wb_cnt <= wb_cnt + 1'b1;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                sda_oe <= ~LEN_BYTE[7];
                shreg  <= {LEN_BYTE[6:0], 1'b0};
                st     <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_RX;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
              end else begin
                sda_oe <= ~shreg[7];
                shreg  <= {shreg[6:0], 1'b0};
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
            end else if (scl_fall) begin
              if (mack) begin
                sda_oe <= ~tx_next[7];
                shreg  <= {tx_next[6:0], 1'b0};
                bitcnt <= '0;
                st     <= ST_TX;
                if (rd_cnt != RW'(NREG)) rd_cnt <= rd_cnt + 1'b1;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: ;  // ST_IDLE waits for a start
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave #(
  parameter int                NREG     = 6,
  parameter logic [6:0]        DEV_ADDR = 7'h69,
  parameter logic [NREG*8-1:0] DEFAULTS = 48'h00_00_06_FF_FF_87,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] regs_o
);
  localparam int IW = $clog2(NREG);

  logic          sda_lvl, scl_rise, scl_fall, start_seen, stop_seen;
  logic          wr_en, eng_idle;
  logic [IW-1:0] wr_idx;
  logic [7:0]    wr_data;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_seen(start_seen), .stop_seen(stop_seen)
  );

  i2c_cfg_engine #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_seen(start_seen), .stop_seen(stop_seen),
    .rd_bus(regs_o), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .idle(eng_idle)
  );

  cfg_reg_bank #(.NREG(NREG), .DEFAULTS(DEFAULTS)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .regs_o(regs_o)
  );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk #(
  parameter int NREG = 6,
  parameter int IW   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] regs_o,
  input logic              eng_idle,
  input logic              wr_en,
  input logic [IW-1:0]     wr_idx
);
  // R3: the data line is only pulled low while SCL is low
  assert_ack_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_i);

  // R5: register contents only move while SCL is low
  assert_reg_update_scl_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs_o) |-> !scl_i);

  // R10: an idle engine never drives the data line
  assert_idle_released_R10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> !sda_oe);

  // R6: a write strobe lasts one cycle
  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R6: a write strobe never addresses past the last register
  assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < NREG));
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.NREG(NREG), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .regs_o(regs_o), .eng_idle(eng_idle), .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/cfg_i2c_slave_tb.sv
`timescale 1ns/1ps
module cfg_i2c_slave_tb;
  localparam int Q = 10;  // quarter bus bit in system clocks
  localparam logic [7:0] DEF [6] = '{8'h87, 8'hFF, 8'hFF, 8'h06, 8'h00, 8'h00};
  // vector: {data bytes to send, seed}
  localparam logic [11:0] VEC [5] = '{
    {4'd6, 8'hA5}, {4'd2, 8'h3C}, {4'd0, 8'h00}, {4'd8, 8'h5A}, {4'd4, 8'hF0}};

  logic clk = 0, rst_n = 0;
  logic scl = 1, m_sda = 1;
  logic sda_oe;
  logic [47:0] regs_o;
  logic sda_line;
  assign sda_line = m_sda & ~sda_oe;

  int nchk = 0, nerr = 0;
  bit done = 0;
  logic [7:0] model [6];

  always #4 clk = ~clk;

  cfg_i2c_slave u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
                       .sda_oe(sda_oe), .regs_o(regs_o));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] packed_model();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1; wq(); scl = 1; wq(); m_sda = 0; wq(); scl = 0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 0; wq(); scl = 1; wq(); m_sda = 1; wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(); scl = 1; wq(); wq(); scl = 0; wq();
    end
    m_sda = 1; wq(); scl = 1; wq(); ack = ~sda_line; wq(); scl = 0; wq();
  endtask

  task automatic recv_byte(input logic ack_it, output logic [7:0] b);
    m_sda = 1;
    for (int i = 0; i < 8; i++) begin
      wq(); scl = 1; wq(); b = {b[6:0], sda_line}; wq(); scl = 0;
    end
    wq(); m_sda = ~ack_it; wq(); scl = 1; wq(); wq(); scl = 0; wq(); m_sda = 1;
  endtask

  task automatic write_hdr();
    logic a;
    send_byte(8'hD2, a); check("R2 write address ack", a, 1);
    send_byte(8'hE7, a); check("R3 command byte ack", a, 1);
    send_byte(8'h33, a); check("R3 count byte ack", a, 1);
  endtask

  task automatic do_write(input int n, input logic [7:0] seed);
    logic a;
    bus_start(); write_hdr();
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = seed ^ 8'(i * 8'h13);
      send_byte(d, a);
      check(i < 6 ? "R3 data byte ack" : "R6 extra byte ack", a, 1);
      if (i < 6) model[i] = d;
    end
    bus_stop();
  endtask

  task automatic do_read_all();
    logic a; logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a); check("R2 read address ack", a, 1);
    recv_byte(1, b); check("R7 count byte", b, 8'h06);
    for (int i = 0; i < 6; i++) begin
      recv_byte(i != 5, b); check("R7 readback byte", b, model[i]);
    end
    bus_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    logic a; logic [7:0] b;
    for (int i = 0; i < 6; i++) model[i] = DEF[i];
    repeat (5) @(negedge clk); rst_n = 1; repeat (5) @(negedge clk);
    check("R1 default registers", regs_o, packed_model());
    check("R1 data line released", sda_oe, 0);
    do_read_all();  // R7 defaults come back over the bus

    // vector table: write n bytes, check register bus, read all back
    for (int v = 0; v < 5; v++) begin
      do_write(int'(VEC[v][11:8]), VEC[v][7:0]);
      check("R5 R4 R6 register bus after write", regs_o, packed_model());
      do_read_all();
    end

    // R2: foreign address is ignored
    bus_start();
    send_byte(8'hA4, a); check("R2 foreign address nack", a, 0);
    send_byte(8'h00, a); check("R10 silent after mismatch", a, 0);
    send_byte(8'h00, a); check("R10 silent after mismatch", a, 0);
    bus_stop();
    check("R2 no change on mismatch", regs_o, packed_model());

    // R4: stop right after the address
    bus_start(); send_byte(8'hD2, a); check("R2 write address ack", a, 1); bus_stop();
    check("R4 stop after address", regs_o, packed_model());

    // R8: reads past the end return 0xFF
    bus_start(); send_byte(8'hD3, a);
    recv_byte(1, b); check("R7 count byte", b, 8'h06);
    for (int i = 0; i < 6; i++) begin
      recv_byte(1, b); check("R7 readback byte", b, model[i]);
    end
    recv_byte(1, b); check("R8 past end byte", b, 8'hFF);
    recv_byte(0, b); check("R8 past end byte", b, 8'hFF);
    bus_stop();

    // R8: NACK on the count byte releases the line
    bus_start(); send_byte(8'hD3, a);
    recv_byte(0, b); check("R8 count before nack", b, 8'h06);
    recv_byte(0, b); check("R8 line released after nack", b, 8'hFF);
    bus_stop();

    // R9: restart mid-write begins again at reg0
    bus_start(); write_hdr();
    send_byte(8'h11, a); model[0] = 8'h11;
    send_byte(8'h44, a); model[1] = 8'h44;
    bus_start(); write_hdr();
    send_byte(8'h22, a); model[0] = 8'h22;
    bus_stop();
    check("R9 restart writes from reg0", regs_o, packed_model());
    do_read_all();

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule